// File: doc/BRIEF.md
# Half-Bridge Gate Command Interlock

This block sits between the control logic that issues gate commands for a half-bridge and the gate drivers themselves. It accepts two active-high commands, one for the low-side switch and one for the high-side switch, and guarantees that the two drive outputs are never asserted together. Arbitration is based on ownership, not on simple mutual masking. The first command to rise while the other is low becomes the owner and keeps that role for as long as it stays high. Only the owner's level reaches its drive output.

A block input gathers the external protection and blocking conditions. While it is high, the interlock is disabled, ownership is dropped and both drives are forced low. When the block input is released while both commands are high, the low-side command wins. Every input passes through a synchronizer chain before it reaches the arbitration logic, and the drives are registered. With the default two synchronizer stages, an accepted command therefore reaches its drive three clock cycles later.

Top module: `hb_gate_arbiter`

## Requirements
- R1: `drv_lo` and `drv_hi` are never both 1 in the same cycle, for any input sequence.
- R2: With no current owner and the block input low, a command that is high while the other is low becomes owner. `owner` reads 2'b01 for low-side, 2'b10 for high-side and 2'b00 for no owner.
- R3: An owning command keeps ownership for as long as it stays high, whatever the other command does.
- R4: Only the owner's drive can be 1. The drive of the non-owning side stays 0.
- R5: When the owning command falls, ownership returns to none and the owner's drive goes low. The other side's drive rises no earlier than the following cycle.
- R6: While the synchronized block input is high, both drives are 0 and `owner` is 2'b00.
- R7: If both commands are high when the block input is released, the low-side command takes ownership and `drv_lo` goes high.
- R8: If both commands rise in the same cycle with no current owner, the low-side command takes ownership.
- R9: With SYNC_STAGES = 2, a change on a command input reaches its drive output on the third rising edge after the change.
- R10: A synchronous active-low reset clears ownership to 2'b00 and drives both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk | input | 1 | Disable request from fault and blocking conditions, active high, asynchronous to clk |
| cmd_lo | input | 1 | Low-side gate command, asynchronous |
| cmd_hi | input | 1 | High-side gate command, asynchronous |
| drv_lo | output | 1 | Registered low-side drive |
| drv_hi | output | 1 | Registered high-side drive |
| owner | output | 2 | Current owner: 00 none, 01 low-side, 10 high-side |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. Its reference model takes its delay line length from the same parameter, so the three-cycle latency of R9 is checked exactly. This depth also brings two corners within reach: a handover, where the idle cycle between the falling owner and the rising successor can be observed, and a release of the block input while both commands are high. Random command and block patterns then compare both drives and the owner code against the model on every cycle.

// File: rtl/hb_arb_pkg.sv
// Shared types for the half-bridge gate interlock.
package hb_arb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'b00,
        OWN_LO   = 2'b01,
        OWN_HI   = 2'b10
    } owner_e;
endpackage

// File: rtl/hb_sync.sv
// Multi-stage synchronizer for a bundle of independent asynchronous bits.
// Assumes each bit is a level that is held for several clock cycles, so no
// cross-bit coherence is required. The chain clears to zero on reset.
module hb_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage resamples the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_own_fsm.sv
// Ownership state machine. It works on synchronized levels. A falling
// owner always passes through OWN_NONE, which creates the handover gap.
// A blocked interlock is forced to OWN_NONE. From OWN_NONE the low-side
// command has priority.
module hb_own_fsm
    import hb_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   blk_s,
    input  logic   lo_s,
    input  logic   hi_s,
    output owner_e own_q,
    output owner_e own_nxt
);
    // Next-owner decision from the present owner and synchronized inputs.
    always_comb begin
        own_nxt = own_q;
        if (blk_s) begin
            own_nxt = OWN_NONE;
        end else begin
            unique case (own_q)
                OWN_NONE: begin
                    if (lo_s)      own_nxt = OWN_LO;
                    else if (hi_s) own_nxt = OWN_HI;
                end
                OWN_LO:  if (!lo_s) own_nxt = OWN_NONE;
                OWN_HI:  if (!hi_s) own_nxt = OWN_NONE;
                default: own_nxt = OWN_NONE;
            endcase
        end
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) own_q <= OWN_NONE;
        else        own_q <= own_nxt;
    end

    // R6
    blocked_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_s |=> (own_q == OWN_NONE));
    // R3
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_LO && lo_s && !blk_s) |=> (own_q == OWN_LO));
    // R3
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_HI && hi_s && !blk_s) |=> (own_q == OWN_HI));
    // R8
    lo_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_NONE && lo_s && !blk_s) |=> (own_q == OWN_LO));
endmodule

// File: rtl/hb_drive.sv
// Registered drive stage. It decodes the next owner into the two gate
// drives, so the drives change on the same edge as the owner register.
// Assumes own_nxt never jumps directly between the two sides.
module hb_drive
    import hb_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  owner_e own_nxt,
    output logic   drv_lo,
    output logic   drv_hi
);
    // Drive registers follow the decoded next owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_lo <= 1'b0;
            drv_hi <= 1'b0;
        end else begin
            drv_lo <= (own_nxt == OWN_LO);
            drv_hi <= (own_nxt == OWN_HI);
        end
    end

    // R1
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_lo && drv_hi));
    // R5
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_hi) |-> !$past(drv_lo));
    // R5
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_lo) |-> !$past(drv_hi));
endmodule

// File: rtl/hb_gate_arbiter.sv
// Top of the half-bridge gate interlock. It synchronizes the block input
// and both commands, runs the ownership state machine and registers the
// drives. Latency from command to drive is SYNC_STAGES + 1 cycles.
module hb_gate_arbiter
    import hb_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk,
    input  logic       cmd_lo,
    input  logic       cmd_hi,
    output logic       drv_lo,
    output logic       drv_hi,
    output logic [1:0] owner
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw_in;
    logic [NSIG-1:0] syn_in;
    owner_e          own_q;
    owner_e          own_nxt;

    assign raw_in = {blk, cmd_hi, cmd_lo};

    hb_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    hb_own_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .blk_s   (syn_in[2]),
        .lo_s    (syn_in[0]),
        .hi_s    (syn_in[1]),
        .own_q   (own_q),
        .own_nxt (own_nxt)
    );

    hb_drive u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .own_nxt (own_nxt),
        .drv_lo  (drv_lo),
        .drv_hi  (drv_hi)
    );

    assign owner = own_q;

    // R4
    lo_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_lo |-> (owner == 2'b01));
    // R4
    hi_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_hi |-> (owner == 2'b10));
endmodule

// File: tb/test_hb_gate_arbiter.sv
module test_hb_gate_arbiter;
    localparam int STG = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk = 1'b0;
    logic       cmd_lo = 1'b0;
    logic       cmd_hi = 1'b0;
    logic       drv_lo;
    logic       drv_hi;
    logic [1:0] owner;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Behavioural model: delay queues and an integer owner
    // (0 none, 1 low, 2 high).
    int q_lo[$];
    int q_hi[$];
    int q_bk[$];
    int m_own = 0;

    always #5 clk = ~clk;

    hb_gate_arbiter #(.SYNC_STAGES(STG)) i_hb_gate_arbiter (
        .clk(clk), .rst_n(rst_n), .blk(blk), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
        .drv_lo(drv_lo), .drv_hi(drv_hi), .owner(owner)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic qreset();
        q_lo.delete(); q_hi.delete(); q_bk.delete();
        for (int i = 0; i < STG; i++) begin
            q_lo.push_back(0); q_hi.push_back(0); q_bk.push_back(0);
        end
        m_own = 0;
    endtask

    initial qreset();

    always @(posedge clk) begin
        if (!rst_n) begin
            qreset();
        end else begin
            int l, h, b;
            l = q_lo.pop_front(); h = q_hi.pop_front(); b = q_bk.pop_front();
            if (b != 0) m_own = 0;
            else if (m_own == 0) m_own = (l != 0) ? 1 : ((h != 0) ? 2 : 0);
            else if (m_own == 1 && l == 0) m_own = 0;
            else if (m_own == 2 && h == 0) m_own = 0;
            q_lo.push_back(int'(cmd_lo)); q_hi.push_back(int'(cmd_hi));
            q_bk.push_back(int'(blk));
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(!(drv_lo && drv_hi), "R1", {drv_lo, drv_hi}, 0);
            chk(int'(owner) == m_own, "R2", owner, m_own);
            chk(int'(drv_lo) == int'(m_own == 1), "R4", drv_lo, m_own == 1);
            chk(int'(drv_hi) == int'(m_own == 2), "R4", drv_hi, m_own == 2);
        end
    end

    task automatic drive(input bit l, input bit h, input bit b);
        @(negedge clk);
        cmd_lo = l; cmd_hi = h; blk = b;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        chk(drv_lo == 0 && drv_hi == 0 && owner == 0, "R10", owner, 0);
        rst_n = 1'b1;
        wait_n(2);

        // R9 latency and R2 low-side acquisition
        drive(1, 0, 0);
        wait_n(2);
        chk(drv_lo == 0, "R9", drv_lo, 0);
        wait_n(1);
        chk(drv_lo == 1 && owner == 2'b01, "R9", drv_lo, 1);

        // R3 hold while the other side also asserts
        drive(1, 1, 0);
        wait_n(5);
        chk(drv_lo == 1 && drv_hi == 0, "R3", {drv_lo, drv_hi}, 2);

        // R5 handover with one idle cycle
        drive(0, 1, 0);
        wait_n(3);
        chk(drv_lo == 0 && drv_hi == 0 && owner == 0, "R5", owner, 0);
        wait_n(1);
        chk(drv_hi == 1 && owner == 2'b10, "R5", owner, 2);

        // R8 simultaneous rise from idle
        drive(0, 0, 0);
        wait_n(5);
        drive(1, 1, 0);
        wait_n(3);
        chk(drv_lo == 1 && drv_hi == 0 && owner == 2'b01, "R8", owner, 1);

        // R6 blocking forces everything low
        drive(1, 1, 1);
        wait_n(3);
        chk(drv_lo == 0 && drv_hi == 0 && owner == 0, "R6", owner, 0);
        wait_n(4);
        chk(drv_lo == 0 && drv_hi == 0, "R6", {drv_lo, drv_hi}, 0);

        // R7 release of the block with both commands high
        drive(1, 1, 0);
        wait_n(3);
        chk(drv_lo == 1 && owner == 2'b01, "R7", owner, 1);

        // R2 high-side acquisition from idle
        drive(0, 0, 0);
        wait_n(4);
        drive(0, 1, 0);
        wait_n(3);
        chk(drv_hi == 1 && owner == 2'b10, "R2", owner, 2);

        // Random patterns, compared every cycle by the model
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 11) == 0);
            if (($urandom % 4) != 0) wait_n($urandom % 4);
        end

        // R10 synchronous reset mid-run
        drive(1, 0, 0);
        wait_n(5);
        @(negedge clk) rst_n = 1'b0;
        wait_n(1);
        chk(drv_lo == 0 && owner == 0, "R10", owner, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule